// File: doc/BRIEF.md
# Two-Function Configuration Request Completer

This block answers PCIe requests on behalf of an Endpoint whose built-in configuration space is bypassed, so that configuration space for two functions lives in application logic. Requests arrive on a narrow receive stream, one 32-bit dword per beat, marked with start and end flags. Three header dwords come first, then any payload dwords. The block decodes each request and performs at most one 32-bit access to the register set of the function it targets. When a reply is required, it builds a completion and sends it on a transmit stream of the same shape.

Each function holds a small configuration header: identity, a command field, a header-type byte that flags a multi-function device, and a base address register pair. The BAR pair describes a 1 MiB window of 64-bit prefetchable memory. Each function also has two 32-bit memory-mapped registers. Memory space is a single 2 MiB region at a parameterised base. Address bit 20 selects the function, and within a window dword index 0 or 1 selects the register. Each request type is handled by a fixed policy: it is completed, dropped, refused with Unsupported Request, or refused with Completer Abort.

Top module: `cbc_completer`

## Requirements
- R1: `rx_ready` is high while the block is idle. From the cycle after an end beat is accepted, `rx_ready` stays low. For a request without a completion it is low for exactly one cycle. For a request with a completion it is low until the cycle after the last completion beat is taken. `tx_valid` is never high while `rx_ready` is high.
- R2: A Configuration Read Type 0 (header dword 0 bits 31:29 = 000, bits 28:24 = 00100) to function 0 or 1 produces a 4-dword completion with data and status 000. The function number is in header dword 2 bits 18:16 and the register number in bits 11:2. The data is that function's configuration register.
- R3: A Configuration Write Type 0 (bits 31:29 = 010, bits 28:24 = 00100) to function 0 or 1 updates the writable bits of the addressed register from the first payload dword. It returns a 3-dword completion with status 000 and no data.
- R4: A configuration read or write to a function number of 2 or more returns status 001 with no data and changes no register.
- R5: Configuration register layout, in which unlisted registers read zero and read-only bits ignore writes:
  - Register 0 reads {DEVICE_ID + function, VENDOR_ID}.
  - Register 1 holds a 3-bit command field in bits 2:0, and its other bits read zero.
  - Register 3 reads 0x0080_0000.
- R6: BAR0 low (register 4) reads {base[31:20], 16'h0, 4'hC}, and only bits 31:20 can be written. BAR0 high (register 5) is fully writable.
- R7: A Memory Read (000 / 00000) of length 1 inside the region returns a completion with data and status 000. The completer function is address bit 20. The data is the function's register at dword index address[19:2], and indices other than 0 and 1 read zero.
- R8: A Memory Write (010 / 00000) of length 1 inside the region writes the payload to that register and produces no completion.
- R9: A Memory Read whose length field (header dword 0 bits 9:0) is not 1 returns status 100 with no data. A Memory Write whose length is not 1 is discarded without effect or completion.
- R10: A Message with data (bits 31:29 = 011) and any other unlisted format/type is discarded without effect or completion.
- R11: A Memory Read outside the region returns status 001 with no data. A Memory Write outside the region is discarded.
- R12: A completion is laid out as follows, and each beat holds steady while `tx_ready` is low:
  - dword 0 is {010 with data or 000 without, 01010, 14'h0, length 1 or 0}.
  - dword 1 is {8'h00, 5'h00, function[2:0], status[2:0], 0, byte count 4}.
  - dword 2 is {requester ID, tag, 0, lower address}. The lower address is address[6:2]<<2 for memory reads and 0 for configuration requests.
  - dword 3 is the data.
- R13: Reset clears the command fields, the BAR pairs and the memory registers to zero and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Request beat present |
| rx_sop | input | 1 | First beat of a request |
| rx_eop | input | 1 | Last beat of a request |
| rx_data | input | 32 | Request dword |
| rx_ready | output | 1 | Block takes the beat at this edge |
| tx_valid | output | 1 | Completion beat present |
| tx_sop | output | 1 | First completion beat |
| tx_eop | output | 1 | Last completion beat |
| tx_data | output | 32 | Completion dword |
| tx_ready | input | 1 | Downstream takes the beat |

## Verification
The two functions that collide are completion sending and request intake. A new request's start beat is already waiting on the receive side while the final completion beat is handed off, often under a pseudo-random `tx_ready` stall pattern. The reference model expects `rx_ready` to stay low in the handoff cycle and to rise in the following one. It also expects the waiting request to be accepted only then, and the following completion to carry values that reflect every earlier write.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [2:0] {RK_DROP, RK_MRD, RK_MWR, RK_CFGRD, RK_CFGWR} req_kind_e;
    typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_SEND} phase_e;

    localparam logic [2:0] CPL_SC = 3'b000;
    localparam logic [2:0] CPL_UR = 3'b001;
    localparam logic [2:0] CPL_CA = 3'b100;

    localparam logic [2:0] FMT_NODATA = 3'b000;
    localparam logic [2:0] FMT_DATA   = 3'b010;
    localparam logic [4:0] TYP_MEM    = 5'b00000;
    localparam logic [4:0] TYP_CFG0   = 5'b00100;
    localparam logic [4:0] TYP_CPL    = 5'b01010;

    typedef struct packed {
        req_kind_e   kind;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [9:0]  len;
        logic [31:2] addr;
        logic [2:0]  fn;
        logic [9:0]  regn;
        logic [31:0] wdata;
        logic        has_pay;
    } req_t;

    typedef struct packed {
        logic        with_data;
        logic [2:0]  status;
        logic [2:0]  fn;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [6:0]  lo_addr;
        logic [31:0] data;
    } cpl_t;

    function automatic req_kind_e classify(input logic [2:0] fmt, input logic [4:0] typ);
        case ({fmt, typ})
            {FMT_NODATA, TYP_MEM}:  return RK_MRD;
            {FMT_DATA,   TYP_MEM}:  return RK_MWR;
            {FMT_NODATA, TYP_CFG0}: return RK_CFGRD;
            {FMT_DATA,   TYP_CFG0}: return RK_CFGWR;
            default:                return RK_DROP;
        endcase
    endfunction

    function automatic logic [31:0] cpl_word(input cpl_t c, input logic [1:0] idx);
        case (idx)
            2'd0:    return {c.with_data ? FMT_DATA : FMT_NODATA, TYP_CPL, 14'h0,
                             c.with_data ? 10'd1 : 10'd0};
            2'd1:    return {8'h00, 5'h00, c.fn, c.status, 1'b0, 12'd4};
            2'd2:    return {c.rid, c.tag, 1'b0, c.lo_addr};
            default: return c.data;
        endcase
    endfunction

endpackage

// File: rtl/cbc_rx_capture.sv
module cbc_rx_capture
    import cbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        sop,
    input  logic [31:0] data,
    output req_t        req
);
    logic [31:0] hw0, hw1, hw2, pay;
    logic [2:0]  beat;
    logic        got_pay;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw0 <= '0; hw1 <= '0; hw2 <= '0; pay <= '0;
            beat <= '0; got_pay <= 1'b0;
        end else if (take) begin
            if (sop) begin
                hw0     <= data;
                beat    <= 3'd1;
                got_pay <= 1'b0;
            end else begin
                case (beat)
                    3'd1: hw1 <= data;
                    3'd2: hw2 <= data;
                    3'd3: begin pay <= data; got_pay <= 1'b1; end
                    default: ;
                endcase
                if (beat != 3'd4) beat <= beat + 3'd1;
            end
        end
    end

    always_comb begin
        req.kind    = classify(hw0[31:29], hw0[28:24]);
        req.len     = hw0[9:0];
        req.rid     = hw1[31:16];
        req.tag     = hw1[15:8];
        req.addr    = hw2[31:2];
        req.fn      = hw2[18:16];
        req.regn    = hw2[11:2];
        req.wdata   = pay;
        req.has_pay = got_pay;
    end

    logic unused_hdr_bits;
    assign unused_hdr_bits = ^{hw0[23:10], hw1[7:0], hw2[1:0]};
endmodule

// File: rtl/cbc_func_regs.sv
module cbc_func_regs #(
    parameter int          FN_IDX    = 0,
    parameter logic [15:0] VENDOR_ID = 16'h1E5A,
    parameter logic [15:0] DEVICE_ID = 16'h7100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [9:0]  cfg_regn,
    input  logic        mem_we,
    input  logic        mem_sel,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] mem_rdata
);
    localparam int          NUM_MREG = 2;
    localparam logic [15:0] MY_DEV   = DEVICE_ID + 16'(FN_IDX);

    logic [2:0]  cmd;
    logic [11:0] bar_lo;
    logic [31:0] bar_hi;
    logic [31:0] mregs [NUM_MREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0; bar_lo <= '0; bar_hi <= '0;
        end else if (cfg_we) begin
            case (cfg_regn)
                10'd1: cmd    <= wdata[2:0];
                10'd4: bar_lo <= wdata[31:20];
                10'd5: bar_hi <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_MREG; i++) begin : g_mreg
        always_ff @(posedge clk) begin
            if (rst)                               mregs[i] <= '0;
            else if (mem_we && (mem_sel == i[0])) mregs[i] <= wdata;
        end
    end

    always_comb begin
        case (cfg_regn)
            10'd0:   cfg_rdata = {MY_DEV, VENDOR_ID};
            10'd1:   cfg_rdata = {29'h0, cmd};
            10'd3:   cfg_rdata = 32'h0080_0000;
            10'd4:   cfg_rdata = {bar_lo, 16'h0, 4'hC};
            10'd5:   cfg_rdata = bar_hi;
            default: cfg_rdata = '0;
        endcase
    end

    assign mem_rdata = mregs[mem_sel];
endmodule

// File: rtl/cbc_cpl_tx.sv
module cbc_cpl_tx
    import cbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  cpl_t        cpl_in,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic [31:0] tx_data,
    output logic        done
);
    cpl_t       cpl_q;
    logic [1:0] idx;
    logic       active;
    logic       last;

    assign last     = idx == (cpl_q.with_data ? 2'd3 : 2'd2);
    assign tx_valid = active;
    assign tx_sop   = active && (idx == 2'd0);
    assign tx_eop   = active && last;
    assign tx_data  = cpl_word(cpl_q, idx);
    assign done     = active && tx_ready && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_q <= '0; idx <= '0; active <= 1'b0;
        end else if (load) begin
            cpl_q <= cpl_in; idx <= '0; active <= 1'b1;
        end else if (active && tx_ready) begin
            if (last) active <= 1'b0;
            else      idx    <= idx + 2'd1;
        end
    end

    p_hold_beat_r12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)));

    p_status_legal_r12: assert property (@(posedge clk) disable iff (rst)
        (active && idx == 2'd1) |-> (tx_data[15:13] == CPL_SC || tx_data[15:13] == CPL_UR
                                     || tx_data[15:13] == CPL_CA));
endmodule

// File: rtl/cbc_completer.sv
module cbc_completer
    import cbc_pkg::*;
#(
    parameter int          NUM_FN    = 2,
    parameter int          WIN_BITS  = 20,
    parameter logic [31:0] MEM_BASE  = 32'h4000_0000,
    parameter logic [15:0] VENDOR_ID = 16'h1E5A,
    parameter logic [15:0] DEVICE_ID = 16'h7100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic [31:0] rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic        tx_sop,
    output logic        tx_eop,
    output logic [31:0] tx_data,
    input  logic        tx_ready
);
    localparam int FN_W    = $clog2(NUM_FN);
    localparam int REG_LSB = WIN_BITS + FN_W;

    phase_e      phase;
    req_t        req;
    cpl_t        cpl_n;
    logic        take, send_n, do_cfg_wr, do_mem_wr, tx_done;
    logic        in_region, mem_ok, cfn_ok;
    logic [FN_W-1:0] mfn, tgt_fn;
    logic [31:0] cfg_rd [NUM_FN];
    logic [31:0] mem_rd [NUM_FN];

    assign rx_ready = (phase == PH_IDLE);
    assign take     = rx_valid && rx_ready;

    cbc_rx_capture u_rx (
        .clk(clk), .rst(rst), .take(take), .sop(rx_sop), .data(rx_data), .req(req)
    );

    assign in_region = req.addr[31:REG_LSB] == MEM_BASE[31:REG_LSB];
    assign mfn       = req.addr[WIN_BITS +: FN_W];
    assign mem_ok    = req.addr[WIN_BITS-1:3] == '0;
    assign cfn_ok    = 32'(req.fn) < NUM_FN;

    always_comb begin
        cpl_n      = '0;
        cpl_n.rid  = req.rid;
        cpl_n.tag  = req.tag;
        send_n     = 1'b0;
        do_cfg_wr  = 1'b0;
        do_mem_wr  = 1'b0;
        tgt_fn     = req.fn[FN_W-1:0];
        case (req.kind)
            RK_CFGRD, RK_CFGWR: begin
                send_n   = 1'b1;
                cpl_n.fn = req.fn;
                if (!cfn_ok) begin
                    cpl_n.status = CPL_UR;
                end else if (req.kind == RK_CFGRD) begin
                    cpl_n.with_data = 1'b1;
                    cpl_n.data      = cfg_rd[tgt_fn];
                end else begin
                    do_cfg_wr = 1'b1;
                end
            end
            RK_MRD: begin
                send_n        = 1'b1;
                tgt_fn        = mfn;
                cpl_n.fn      = 3'(mfn);
                cpl_n.lo_addr = {req.addr[6:2], 2'b00};
                if (!in_region)            cpl_n.status = CPL_UR;
                else if (req.len != 10'd1) cpl_n.status = CPL_CA;
                else begin
                    cpl_n.with_data = 1'b1;
                    cpl_n.data      = mem_ok ? mem_rd[tgt_fn] : '0;
                end
            end
            RK_MWR: begin
                tgt_fn    = mfn;
                do_mem_wr = in_region && (req.len == 10'd1) && req.has_pay && mem_ok;
            end
            default: ;
        endcase
    end

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
        cbc_func_regs #(.FN_IDX(f), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (phase == PH_EXEC && do_cfg_wr && 32'(tgt_fn) == f),
            .cfg_regn  (req.regn),
            .mem_we    (phase == PH_EXEC && do_mem_wr && 32'(tgt_fn) == f),
            .mem_sel   (req.addr[2]),
            .wdata     (req.wdata),
            .cfg_rdata (cfg_rd[f]),
            .mem_rdata (mem_rd[f])
        );
    end

    cbc_cpl_tx u_tx (
        .clk(clk), .rst(rst), .load(phase == PH_EXEC && send_n), .cpl_in(cpl_n),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_data(tx_data), .done(tx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else begin
            case (phase)
                PH_IDLE: if (take && rx_eop) phase <= PH_EXEC;
                PH_EXEC: phase <= send_n ? PH_SEND : PH_IDLE;
                PH_SEND: if (tx_done) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_quiet_rx_during_cpl_r1: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

    p_reopen_after_cpl_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_eop) |=> rx_ready);

    p_drop_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && !send_n) |=> (rx_ready && !tx_valid));

    p_cpl_starts_r12: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && send_n) |=> (tx_valid && tx_sop));
endmodule

// File: tb/cbc_completer_tb.sv
`timescale 1ns/1ps
module cbc_completer_tb;
    localparam logic [15:0] VID  = 16'h1E5A;
    localparam logic [15:0] DID  = 16'h7100;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [15:0] RID  = 16'h0100;

    logic        clk = 1'b0, rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_ready, tx_valid, tx_sop, tx_eop;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b1;

    cbc_completer u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    always #2.5 clk = ~clk;

    int          total = 0, bad = 0;
    logic [31:0] exp_q[$];
    string       exp_tag[$];
    int          phase_m = 0, beat_m = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'h5A;
    logic [7:0]  tg = 8'h00;

    logic [2:0]  m_cmd [2];
    logic [11:0] m_barlo [2];
    logic [31:0] m_barhi [2];
    logic [31:0] m_mem [2][2];

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int f = 0; f < 2; f++) begin
            m_cmd[f] = '0; m_barlo[f] = '0; m_barhi[f] = '0;
            m_mem[f][0] = '0; m_mem[f][1] = '0;
        end
    endtask

    function automatic logic [31:0] cfg_val(input int f, input int rn);
        case (rn)
            0: return {DID + 16'(f), VID};
            1: return {29'h0, m_cmd[f]};
            3: return 32'h0080_0000;
            4: return {m_barlo[f], 16'h0, 4'hC};
            5: return m_barhi[f];
            default: return 32'h0;
        endcase
    endfunction

    task automatic mk_cpl(ref logic [31:0] q[$], input bit wd, input logic [2:0] st,
                          input logic [2:0] fn, input logic [15:0] rid, input logic [7:0] tag,
                          input logic [6:0] lo, input logic [31:0] data);
        q.push_back({wd ? 3'b010 : 3'b000, 5'b01010, 14'h0, wd ? 10'd1 : 10'd0});
        q.push_back({8'h00, 5'h00, fn, st, 1'b0, 12'd4});
        q.push_back({rid, tag, 1'b0, lo});
        if (wd) q.push_back(data);
    endtask

    task automatic predict(input logic [31:0] d0, d1, d2, input int npay,
                           input logic [31:0] pay, ref logic [31:0] q[$]);
        logic [7:0]  ft   = d0[31:24];
        int          len  = int'(d0[9:0]);
        logic [15:0] rid  = d1[31:16];
        logic [7:0]  tag  = d1[15:8];
        int          cf   = int'(d2[18:16]);
        int          rn   = int'(d2[11:2]);
        int          mf   = int'(d2[20]);
        bit          inr  = d2[31:21] == BASE[31:21];
        bit          okix = d2[19:3] == 17'h0;
        int          ix   = int'(d2[2]);
        logic [6:0]  lo   = d2[6:0] & 7'h7C;
        if (ft == 8'h04 || ft == 8'h44) begin
            if (cf > 1) mk_cpl(q, 0, 3'b001, 3'(cf), rid, tag, 7'h0, 32'h0);
            else if (ft == 8'h04) mk_cpl(q, 1, 3'b000, 3'(cf), rid, tag, 7'h0, cfg_val(cf, rn));
            else begin
                if (rn == 1) m_cmd[cf]   = pay[2:0];
                if (rn == 4) m_barlo[cf] = pay[31:20];
                if (rn == 5) m_barhi[cf] = pay;
                mk_cpl(q, 0, 3'b000, 3'(cf), rid, tag, 7'h0, 32'h0);
            end
        end else if (ft == 8'h00) begin
            if (!inr) mk_cpl(q, 0, 3'b001, 3'(mf), rid, tag, lo, 32'h0);
            else if (len != 1) mk_cpl(q, 0, 3'b100, 3'(mf), rid, tag, lo, 32'h0);
            else mk_cpl(q, 1, 3'b000, 3'(mf), rid, tag, lo, okix ? m_mem[mf][ix] : 32'h0);
        end else if (ft == 8'h40) begin
            if (inr && len == 1 && npay >= 1 && okix) m_mem[mf][ix] = pay;
        end
    endtask

    task automatic issue(input string t, input logic [31:0] d0, d1, d2,
                         input int npay, input logic [31:0] pay);
        logic [31:0] lq[$];
        int nb = 3 + npay;
        predict(d0, d1, d2, npay, pay, lq);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == nb - 1);
            rx_data  = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : pay + 32'(i - 3);
            while (!rx_ready) @(negedge clk);
        end
        foreach (lq[k]) begin exp_q.push_back(lq[k]); exp_tag.push_back(t); end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    task automatic cfg_rd(input string t, input int f, input int rn);
        tg++;
        issue(t, {8'h04, 14'h0, 10'd1}, {RID, tg, 8'h0F},
              {8'h00, 5'h00, 3'(f), 4'h0, 10'(rn), 2'b00}, 0, 32'h0);
    endtask

    task automatic cfg_wr(input string t, input int f, input int rn, input logic [31:0] v);
        tg++;
        issue(t, {8'h44, 14'h0, 10'd1}, {RID, tg, 8'h0F},
              {8'h00, 5'h00, 3'(f), 4'h0, 10'(rn), 2'b00}, 1, v);
    endtask

    task automatic mem_rd(input string t, input logic [31:0] a, input int len);
        tg++;
        issue(t, {8'h00, 14'h0, 10'(len)}, {RID, tg, 8'h0F}, a, 0, 32'h0);
    endtask

    task automatic mem_wr(input string t, input logic [31:0] a, input int len, input logic [31:0] v);
        tg++;
        issue(t, {8'h40, 14'h0, 10'(len)}, {RID, tg, 8'h0F}, a, len, v);
    endtask

    task automatic drain();
        do @(negedge clk); while (phase_m != 0 || exp_q.size() != 0);
        repeat (2) @(negedge clk);
    endtask

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = stall_en ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk("R1 rx_ready vs model", 32'(rx_ready), 32'(phase_m == 0));
            chk("R12 tx_valid vs model", 32'(tx_valid), 32'(phase_m == 2));
            if (tx_valid && phase_m == 2 && exp_q.size() > 0) begin
                chk(exp_tag[0], tx_data, exp_q[0]);
                chk("R12 tx_sop", 32'(tx_sop), 32'(beat_m == 0));
                chk("R12 tx_eop", 32'(tx_eop), 32'(exp_q.size() == 1));
            end
            case (phase_m)
                0: if (rx_valid && rx_ready && rx_eop) phase_m = 1;
                1: begin phase_m = (exp_q.size() > 0) ? 2 : 0; beat_m = 0; end
                default: if (tx_valid && tx_ready && exp_q.size() > 0) begin
                    void'(exp_q.pop_front());
                    void'(exp_tag.pop_front());
                    beat_m++;
                    if (exp_q.size() == 0) phase_m = 0;
                end
            endcase
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R13 reset rx_ready", 32'(rx_ready), 32'd1);
        chk("R13 reset tx_valid", 32'(tx_valid), 32'd0);

        cfg_rd("R13 cmd after reset", 0, 1);
        cfg_rd("R13 bar low after reset", 1, 4);
        mem_rd("R13 mem after reset", BASE, 1);
        cfg_rd("R5 identity fn0", 0, 0);
        cfg_rd("R5 identity fn1", 1, 0);
        cfg_rd("R5 header type", 0, 3);
        cfg_rd("R5 unlisted reads zero", 1, 2);

        cfg_wr("R3 cmd write", 0, 1, 32'hFFFF_FFFF);
        cfg_rd("R5 cmd mask", 0, 1);
        cfg_rd("R3 other fn untouched", 1, 1);
        cfg_wr("R3 bar low write", 1, 4, 32'hFFFF_FFFF);
        cfg_rd("R6 bar low mask", 1, 4);
        cfg_wr("R3 bar high write", 1, 5, 32'h1234_5678);
        cfg_rd("R6 bar high", 1, 5);
        cfg_wr("R5 identity read-only", 0, 0, 32'h0);
        cfg_rd("R2 identity after write", 0, 0);

        cfg_rd("R4 read fn2", 2, 0);
        cfg_wr("R4 write fn5", 5, 1, 32'h7);
        cfg_rd("R4 fn1 cmd unchanged", 1, 1);

        mem_wr("R8 write fn0 r0", BASE + 32'h0, 1, 32'hA5A5_0001);
        mem_wr("R8 write fn1 r1", BASE + 32'h0010_0004, 1, 32'h5A5A_0002);
        mem_rd("R7 read fn0 r0", BASE + 32'h0, 1);
        mem_rd("R7 read fn1 r1", BASE + 32'h0010_0004, 1);
        mem_rd("R7 read fn0 r1", BASE + 32'h4, 1);
        mem_rd("R7 index beyond regs", BASE + 32'h0010_0014, 1);

        mem_rd("R9 long read abort", BASE + 32'h4, 2);
        mem_wr("R9 long write dropped", BASE + 32'h0, 3, 32'hDEAD_0000);
        mem_rd("R9 after long write", BASE + 32'h0, 1);

        tg++;
        issue("R10 message dropped", {8'h70, 14'h0, 10'd1}, {RID, tg, 8'h00}, BASE, 1, 32'hBAD0_0000);
        tg++;
        issue("R10 unknown type dropped", {8'h1F, 14'h0, 10'd1}, {RID, tg, 8'h00}, BASE, 0, 32'h0);
        mem_rd("R10 after drops", BASE + 32'h0, 1);

        mem_rd("R11 read outside", 32'h8000_0044, 1);
        mem_wr("R11 write outside", 32'h8000_0000, 1, 32'hFFFF_0000);
        mem_rd("R11 after outside write", BASE + 32'h0, 1);

        stall_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            mem_wr("R12 stalled write", BASE + 32'(k[0]) * 32'h0010_0000 + 32'h4, 1, 32'(k) * 32'h0101_0101);
            mem_rd("R12 stalled read", BASE + 32'(k[0]) * 32'h0010_0000 + 32'h4, 1);
            cfg_rd("R2 stalled cfg read", k % 2, 1);
        end
        drain();
        stall_en = 1'b0;

        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_clear();
        exp_q.delete(); exp_tag.delete(); phase_m = 0;
        rst = 1'b0;
        cfg_rd("R13 cmd cleared", 0, 1);
        cfg_rd("R13 bar high cleared", 1, 5);
        mem_rd("R13 mem cleared", BASE + 32'h0010_0004, 1);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule